// File: doc/BRIEF.md
# Interrupt Moderation Throttle Timer

This block limits how often an event-driven interrupt line may fire. Software programs a 16-bit moderation interval, counted in 250 ns steps, and can also load a 16-bit moderation down-counter directly. Each time the interrupt-pending flag is cleared, the counter takes the interval value. It then counts down once per 250 ns tick until it reaches zero, where it stays. The request output is only allowed through while the counter sits at zero, so two interrupts are always at least one interval apart.

When the interval is set to zero, the throttle is bypassed. The request then follows the ring and handler state with no waiting. A prescaler divides the system clock down to the 250 ns tick. Both fields share one 32-bit register. It is written through a byte-enabled write port and read back on a continuous read bus.

Top module: `thr_moderator`

## Requirements
- R1: After reset, `rd_data` reads 0x00000FA0: the counter is zero and the interval is 4000. `irq_req` is low and the prescaler starts from zero.
- R2: A `pending_clr` pulse loads the counter with the interval value held in that cycle. The loaded value is visible on `rd_data[31:16]` in the following cycle.
- R3: The counter only decrements on a prescaler tick, and by exactly one each time. Ticks come every `CLK_PER_TICK` clock cycles, which is 50 at the default setting.
- R4: Once the counter reaches zero it stays at zero until it is reloaded or written. It never wraps to 0xFFFF.
- R5: A software write to the counter shows on readback in the next cycle. If a tick falls in the same cycle, the write wins. If a `pending_clr` falls in the same cycle, the reload wins over the write.
- R6: With a nonzero interval, `irq_req` is high one cycle after a cycle in which all of these hold: counter == 0, `ring_nonempty`=1, `int_enable`=1, `int_pending`=1 and `handler_busy`=0. If any of them fails, `irq_req` is low one cycle later.
- R7: With a zero interval, `irq_req` is high one cycle after a cycle with `int_pending`=0, `handler_busy`=0 and `ring_nonempty`=1. In this mode the counter value and `int_enable` have no effect.
- R8: `irq_req` is a register output. It falls in the cycle after any of its gating conditions drops, in either mode.
- R9: The register layout is counter in bits 31:16 and interval in bits 15:0. `wr_be[n]` enables byte n, which is bits 8n+7 down to 8n. A write changes only the enabled bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data: counter in 31:16, interval in 15:0 |
| rd_data | output | 32 | Readback of the counter and interval |
| ring_nonempty | input | 1 | Event ring holds at least one entry |
| int_enable | input | 1 | Interrupt enable flag |
| int_pending | input | 1 | Interrupt pending flag |
| handler_busy | input | 1 | Event handler busy flag |
| pending_clr | input | 1 | One-cycle pulse: pending flag was cleared |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The bench first times two successive counter steps and requires them to be exactly one tick period apart. A prescaler off by one, or a counter that steps every clock, would show a wrong spacing.

It places a software write on the exact cycle of a tick. A design with the wrong priority would read back the written value minus one. It also reloads and writes in the same cycle to show that the old interval wins.

It leaves an expired counter idle well past several ticks. A design that wraps would read 0xFFFF.

Finally it toggles each gating input in turn in both modes. A missing term in the gate, or a bypass that still consults the counter or the enable, would raise or hold `irq_req` when it should be low.

// File: rtl/thr_pkg.sv
package thr_pkg;
  // Source chosen for the next counter value, in priority order.
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_STEP  = 2'd1,
    CNT_WRITE = 2'd2,
    CNT_LOAD  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/thr_tick_gen.sv
module thr_tick_gen #(
  parameter int CLK_PER_TICK = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (CLK_PER_TICK <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PRE_W = $clog2(CLK_PER_TICK);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_TICK - 1);

      logic [PRE_W-1:0] pre_q;
      logic [PRE_W-1:0] pre_d;
      logic             at_last;

      assign at_last = (pre_q == LAST);

      always_comb begin
        if (at_last) pre_d = '0;
        else         pre_d = pre_q + PRE_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick_o = at_last;
    end
  endgenerate
endmodule

// File: rtl/thr_mod_regs.sv
module thr_mod_regs
  import thr_pkg::*;
#(
  parameter int              FIELD_W   = 16,
  parameter logic [FIELD_W-1:0] IVL_RESET = 16'h0FA0,
  localparam int             REG_W     = 2 * FIELD_W,
  localparam int             NBYTE     = REG_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NBYTE-1:0]   wr_be,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               pending_clr,
  input  logic               tick,
  output logic [FIELD_W-1:0] cnt_o,
  output logic [FIELD_W-1:0] ivl_o
);
  localparam int HALF = NBYTE / 2;

  logic [FIELD_W-1:0] cnt_q, cnt_d;
  logic [FIELD_W-1:0] ivl_q, ivl_d;
  logic [REG_W-1:0]   cur_word;
  logic [REG_W-1:0]   merged;
  logic               cnt_wr, ivl_wr;
  logic               cnt_en, ivl_en;
  cnt_op_e            cnt_op;

  assign cur_word = {cnt_q, ivl_q};

  // Byte-lane merge of write data over the current contents.
  genvar b;
  generate
    for (b = 0; b < NBYTE; b++) begin : g_lane
      assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : cur_word[b*8 +: 8];
    end
  endgenerate

  assign cnt_wr = wr_en && (|wr_be[NBYTE-1:HALF]);
  assign ivl_wr = wr_en && (|wr_be[HALF-1:0]);

  // Counter source select: reload > software write > tick step.
  always_comb begin
    if (pending_clr)                          cnt_op = CNT_LOAD;
    else if (cnt_wr)                          cnt_op = CNT_WRITE;
    else if (tick && (cnt_q != '0))           cnt_op = CNT_STEP;
    else                                      cnt_op = CNT_HOLD;
  end

  always_comb begin
    case (cnt_op)
      CNT_LOAD:  cnt_d = ivl_q;
      CNT_WRITE: cnt_d = merged[REG_W-1:FIELD_W];
      CNT_STEP:  cnt_d = cnt_q - FIELD_W'(1);
      default:   cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = (cnt_op != CNT_HOLD);
  assign ivl_en = ivl_wr;
  assign ivl_d  = merged[FIELD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ivl_q <= IVL_RESET;
    else if (ivl_en) ivl_q <= ivl_d;
  end

  assign cnt_o = cnt_q;
  assign ivl_o = ivl_q;
endmodule

// File: rtl/thr_irq_gate.sv
module thr_irq_gate #(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] cnt,
  input  logic [FIELD_W-1:0] ivl,
  input  logic               ring_nonempty,
  input  logic               int_enable,
  input  logic               int_pending,
  input  logic               handler_busy,
  output logic               irq_o
);
  logic bypass;
  logic fire_throttled;
  logic fire_bypass;
  logic irq_d, irq_q;

  assign bypass         = (ivl == '0);
  assign fire_throttled = (cnt == '0) && ring_nonempty && int_enable
                          && int_pending && !handler_busy;
  assign fire_bypass    = !int_pending && !handler_busy && ring_nonempty;

  always_comb begin
    if (bypass) irq_d = fire_bypass;
    else        irq_d = fire_throttled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/thr_moderator.sv
module thr_moderator #(
  parameter int                 CLK_PER_TICK = 50,
  parameter int                 FIELD_W      = 16,
  parameter logic [FIELD_W-1:0] IVL_RESET    = 16'h0FA0,
  localparam int                REG_W        = 2 * FIELD_W,
  localparam int                NBYTE        = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NBYTE-1:0] wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ring_nonempty,
  input  logic             int_enable,
  input  logic             int_pending,
  input  logic             handler_busy,
  input  logic             pending_clr,
  output logic             irq_req
);
  logic               tick;
  logic [FIELD_W-1:0] cnt;
  logic [FIELD_W-1:0] ivl;

  thr_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  thr_mod_regs #(.FIELD_W(FIELD_W), .IVL_RESET(IVL_RESET)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .pending_clr (pending_clr),
    .tick        (tick),
    .cnt_o       (cnt),
    .ivl_o       (ivl)
  );

  thr_irq_gate #(.FIELD_W(FIELD_W)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt           (cnt),
    .ivl           (ivl),
    .ring_nonempty (ring_nonempty),
    .int_enable    (int_enable),
    .int_pending   (int_pending),
    .handler_busy  (handler_busy),
    .irq_o         (irq_req)
  );

  assign rd_data = {cnt, ivl};
endmodule

// File: rtl/thr_moderator_chk.sv
module thr_moderator_chk #(
  parameter int FIELD_W = 16,
  localparam int REG_W  = 2 * FIELD_W,
  localparam int NBYTE  = REG_W / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [NBYTE-1:0] wr_be,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             ring_nonempty,
  input logic             int_enable,
  input logic             int_pending,
  input logic             handler_busy,
  input logic             pending_clr,
  input logic             irq_req
);
  localparam int HALF = NBYTE / 2;

  logic [FIELD_W-1:0] c_cnt, c_ivl;
  logic               c_cnt_wr, c_cnt_wr_full;
  logic               c_ok_thr;

  assign c_cnt         = rd_data[REG_W-1:FIELD_W];
  assign c_ivl         = rd_data[FIELD_W-1:0];
  assign c_cnt_wr      = wr_en && (|wr_be[NBYTE-1:HALF]);
  assign c_cnt_wr_full = wr_en && (&wr_be[NBYTE-1:HALF]);
  assign c_ok_thr      = (c_cnt == '0) && ring_nonempty && int_enable
                         && int_pending && !handler_busy;

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pending_clr |=> (c_cnt == $past(c_ivl)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_clr && !c_cnt_wr && c_cnt != '0)
      |=> (c_cnt == $past(c_cnt) || c_cnt == $past(c_cnt) - FIELD_W'(1)));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_clr && !c_cnt_wr && c_cnt == '0) |=> (c_cnt == '0));

  p_sw_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cnt_wr_full && !pending_clr) |=> (c_cnt == $past(wr_data[REG_W-1:FIELD_W])));

  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ivl != '0 && c_ok_thr) |=> irq_req);

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ivl != '0 && !c_ok_thr) |=> !irq_req);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ivl == '0 && ring_nonempty && !int_pending && !handler_busy) |=> irq_req);

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_nonempty || handler_busy) |=> !irq_req);
endmodule

bind thr_moderator thr_moderator_chk #(.FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/sim_thr_moderator.sv
module sim_thr_moderator;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ring_nonempty, int_enable, int_pending, handler_busy, pending_clr;
  logic        irq_req;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  thr_moderator u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .ring_nonempty(ring_nonempty), .int_enable(int_enable),
    .int_pending(int_pending), .handler_busy(handler_busy),
    .pending_clr(pending_clr), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; wr_data = d; wr_be = be;
    step(1);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic clr_pulse();
    pending_clr = 1'b1;
    step(1);
    pending_clr = 1'b0;
  endtask

  task automatic t_reset();
    check(rd_data == 32'h00000FA0, "R1 readback", rd_data, 32'h00000FA0);
    check(irq_req == 1'b0, "R1 irq", {31'd0, irq_req}, 32'd0);
  endtask

  task automatic t_reload();
    reg_write(32'h0000_0007, 4'b0011);
    check(rd_data[15:0] == 16'd7, "R9 interval write", rd_data, 32'd7);
    clr_pulse();
    check(rd_data[31:16] == 16'd7, "R2 reload", {16'd0, rd_data[31:16]}, 32'd7);
  endtask

  task automatic t_tick_rate();
    logic [15:0] v0, v1;
    int c0;
    reg_write(32'h0000_0005, 4'b0011);
    clr_pulse();
    v0 = rd_data[31:16];
    for (int i = 0; i < 200 && rd_data[31:16] == v0; i++) step(1);
    v0 = rd_data[31:16]; c0 = cyc;
    for (int i = 0; i < 200 && rd_data[31:16] == v0; i++) step(1);
    v1 = rd_data[31:16];
    check(cyc - c0 == 50, "R3 tick spacing", cyc - c0, 32'd50);
    check(v1 == v0 - 16'd1, "R3 step by one", {16'd0, v1}, {16'd0, v0 - 16'd1});
  endtask

  task automatic t_hold_zero();
    reg_write(32'h0000_0002, 4'b0011);
    clr_pulse();
    step(170);
    check(rd_data[31:16] == 16'd0, "R4 reached zero", {16'd0, rd_data[31:16]}, 32'd0);
    step(200);
    check(rd_data[31:16] == 16'd0, "R4 no wrap", {16'd0, rd_data[31:16]}, 32'd0);
  endtask

  task automatic t_write_prio();
    logic [15:0] v0;
    reg_write(32'h0000_00C8, 4'b0011);
    clr_pulse();
    v0 = rd_data[31:16];
    for (int i = 0; i < 200 && rd_data[31:16] == v0; i++) step(1);
    step(49);
    reg_write(32'h1234_0000, 4'b1100);
    check(rd_data[31:16] == 16'h1234, "R5 write beats tick",
          {16'd0, rd_data[31:16]}, 32'h1234);
    reg_write(32'h00AB_0000, 4'b0100);
    check(rd_data == 32'h12AB_00C8, "R9 byte lane merge", rd_data, 32'h12AB_00C8);
    // reload and write together: reload uses the old interval
    pending_clr = 1'b1;
    reg_write(32'h5555_0009, 4'b1111);
    pending_clr = 1'b0;
    check(rd_data == 32'h00C8_0009, "R5 reload beats write", rd_data, 32'h00C8_0009);
  endtask

  task automatic t_gate();
    reg_write(32'h0000_0002, 4'b0011);
    ring_nonempty = 1; int_enable = 1; int_pending = 1; handler_busy = 0;
    clr_pulse();
    step(1);
    check(irq_req == 1'b0, "R6 held while counting", {31'd0, irq_req}, 32'd0);
    for (int i = 0; i < 300 && rd_data[31:16] != 16'd0; i++) step(1);
    step(1);
    check(irq_req == 1'b1, "R6 fires at zero", {31'd0, irq_req}, 32'd1);
    handler_busy = 1; step(1);
    check(irq_req == 1'b0, "R8 busy drops irq", {31'd0, irq_req}, 32'd0);
    handler_busy = 0; step(1);
    check(irq_req == 1'b1, "R6 refires", {31'd0, irq_req}, 32'd1);
    int_enable = 0; step(1);
    check(irq_req == 1'b0, "R6 enable gate", {31'd0, irq_req}, 32'd0);
    int_enable = 1; int_pending = 0; step(1);
    check(irq_req == 1'b0, "R6 pending gate", {31'd0, irq_req}, 32'd0);
    int_pending = 1; ring_nonempty = 0; step(1);
    check(irq_req == 1'b0, "R8 empty ring drops irq", {31'd0, irq_req}, 32'd0);
  endtask

  task automatic t_bypass();
    ring_nonempty = 1; int_enable = 0; int_pending = 0; handler_busy = 0;
    reg_write(32'h0005_0000, 4'b1111);
    step(1);
    check(irq_req == 1'b1, "R7 bypass fires", {31'd0, irq_req}, 32'd1);
    ring_nonempty = 0; step(1);
    check(irq_req == 1'b0, "R8 bypass drop", {31'd0, irq_req}, 32'd0);
    ring_nonempty = 1; int_pending = 1; step(1);
    check(irq_req == 1'b0, "R7 pending blocks bypass", {31'd0, irq_req}, 32'd0);
    int_pending = 0; handler_busy = 1; step(1);
    check(irq_req == 1'b0, "R7 busy blocks bypass", {31'd0, irq_req}, 32'd0);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_be = 0; wr_data = 0;
    ring_nonempty = 0; int_enable = 0; int_pending = 0; handler_busy = 0;
    pending_clr = 0;
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_reload();
    t_tick_rate();
    t_hold_zero();
    t_write_prio();
    t_gate();
    t_bypass();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule